// File: doc/BRIEF.md
# Converter Output Coding and Demultiplexing Formatter

This block sits between the two conversion channels of a dual sampling converter (called I and Q) and the output pins. Each clock cycle in which `smp_vld` is high, it takes one sample per channel, each with its own out-of-range flag. It then codes each sample as natural binary or as reflected Gray code. In Gray mode an out-of-range sample is forced to a fixed pattern. The coded samples go onto output ports A and B: in single-port mode every sample appears on port A, and in paired mode two consecutive samples appear together, the first on A and the second on B. A registered `drdy` pulse marks each new output word.

A decimation mode passes on only one accepted sample in every sixteen and drops the rest. This lowers both the output word rate and the `drdy` rate by sixteen while the input sampling rate stays the same. The configuration inputs come from a register block.

A change of the pairing mode or of decimation restarts the sample counter and the pairing. The pairing is handled by a two-state machine:
- `ST_PAIR_FIRST` waits for a sample. In paired mode a forwarded sample is held and the machine moves to `ST_PAIR_SECOND` (transition *hold-first*). In single-port mode the sample is sent out at once and the machine stays put (transition *emit-single*).
- `ST_PAIR_SECOND` waits for the partner sample. A forwarded sample sends out the pair and returns the machine to `ST_PAIR_FIRST` (transition *emit-pair*).
- A mode change forces `ST_PAIR_FIRST` (transition *restart*).

Top module: `cvt_out_fmt`

## Requirements
- R1: While `rst_n` is low, all data outputs, both out-of-range outputs and `drdy` are 0.
- R2: In single-port binary mode, a sample forwarded at a rising edge appears unchanged on `a_i`/`a_q` right after that edge. Its flags appear on `ovr_i`/`ovr_q`. An out-of-range flag does not alter binary data.
- R3: In Gray mode, for an in-range sample, output bit k equals input bit k XOR input bit k+1, and the top bit equals the input top bit.
- R4: In Gray mode, an out-of-range sample is output with its top bit unchanged and all lower bits 0.
- R5: In paired mode (`cfg_dmux2`=1), the first forwarded sample of a pair goes to port A and the second to port B. Both appear together after the edge that accepts the second, with a single `drdy` pulse.
- R6: In paired mode, `ovr_i` (`ovr_q`) is the OR of the I (Q) flags of the two samples in the pair.
- R7: In single-port mode, `b_i` and `b_q` are 0 whenever `drdy` is high.
- R8: `drdy` is high for exactly the cycle after an edge that emits a word. Outputs hold their values until the next emitted word. No word is emitted without an accepted sample.
- R9: With `cfg_decim`=1, the first accepted sample after reset or restart is forwarded, then every 16th after it; all other samples are discarded.
- R10: A change of `cfg_dmux2` or `cfg_decim` from the value seen at the previous edge restarts the decimation count and drops an unpaired first sample. A sample accepted at that edge counts as the first. A change of `cfg_gray` restarts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | A new sample pair is present this cycle |
| i_data | input | DW | I channel sample, offset binary |
| i_ovr | input | 1 | I channel out-of-range flag |
| q_data | input | DW | Q channel sample, offset binary |
| q_ovr | input | 1 | Q channel out-of-range flag |
| cfg_gray | input | 1 | 1: Gray output coding, 0: binary |
| cfg_dmux2 | input | 1 | 1: paired A/B output, 0: port A only |
| cfg_decim | input | 1 | 1: forward one sample in sixteen |
| a_i | output | DW | Port A, I channel |
| a_q | output | DW | Port A, Q channel |
| b_i | output | DW | Port B, I channel |
| b_q | output | DW | Port B, Q channel |
| ovr_i | output | 1 | I out-of-range for the emitted word |
| ovr_q | output | 1 | Q out-of-range for the emitted word |
| drdy | output | 1 | One-cycle strobe marking a new output word |

## Verification
The block is driven in several ways, and each exposes a different class of error:
- **Back-to-back samples versus gapped samples.** This separates pairing that follows accepted samples from pairing that follows clock cycles.
- **Random data with random flags in both coding modes.** This shows whether the overflow forcing is limited to Gray mode and keeps the top bit.
- **Runs far longer than sixteen samples in decimation mode.** These expose an off-by-one in the forwarding period.
- **Mode changes placed midway through a pair and midway through a decimation count.** These show whether the restart drops the held sample and treats the new one as first.

// File: rtl/cvt_out_pkg.sv
package cvt_out_pkg;

    typedef enum logic [0:0] {
        ST_PAIR_FIRST  = 1'b0,
        ST_PAIR_SECOND = 1'b1
    } pair_st_t;

    typedef struct packed {
        logic dmux2;
        logic decim;
    } mode_t;

    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/cvt_coder.sv
module cvt_coder #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] raw,
    input  logic          ovr,
    input  logic          gray_en,
    output logic [DW-1:0] coded
);
    logic [DW-1:0] gray;

    assign gray[DW-1] = raw[DW-1];

    genvar k;
    generate
        for (k = 0; k < DW - 1; k++) begin : g_bit
            assign gray[k] = raw[k] ^ raw[k+1];
        end
    endgenerate

    always_comb begin
        if (!gray_en) begin
            coded = raw;
        end else if (ovr) begin
            coded = '0;
            coded[DW-1] = raw[DW-1];
        end else begin
            coded = gray;
        end
    end
endmodule

// File: rtl/cvt_decim.sv
module cvt_decim
    import cvt_out_pkg::*;
#(
    parameter int unsigned RATIO = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  smp_vld,
    input  mode_t mode,
    output logic  fwd,
    output logic  restart
);
    localparam int unsigned CW = (RATIO < 2) ? 1 : $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q, cnt_eff, cnt_d;
    mode_t         mode_q;

    assign restart = (mode != mode_q);
    assign cnt_eff = restart ? '0 : cnt_q;
    assign fwd     = smp_vld && (!mode.decim || (cnt_eff == '0));

    always_comb begin
        cnt_d = cnt_eff;
        if (smp_vld) begin
            cnt_d = (cnt_eff == LAST) ? '0 : cnt_eff + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            mode_q <= mode;
        end
    end
endmodule

// File: rtl/cvt_demux_fsm.sv
module cvt_demux_fsm
    import cvt_out_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd,
    input  logic          restart,
    input  logic          dmux2,
    input  logic [DW-1:0] ci,
    input  logic [DW-1:0] cq,
    input  logic          oi,
    input  logic          oq,
    output logic [DW-1:0] a_i,
    output logic [DW-1:0] a_q,
    output logic [DW-1:0] b_i,
    output logic [DW-1:0] b_q,
    output logic          ovr_i,
    output logic          ovr_q,
    output logic          drdy
);
    pair_st_t st_q, st_eff, st_d;

    logic [DW-1:0] hold_i, hold_q;
    logic          hold_oi, hold_oq;

    assign st_eff = restart ? ST_PAIR_FIRST : st_q;

    // next-state decision
    always_comb begin
        st_d = st_eff;
        unique case (st_eff)
            ST_PAIR_FIRST:  if (fwd && dmux2) st_d = ST_PAIR_SECOND;
            ST_PAIR_SECOND: if (fwd)          st_d = ST_PAIR_FIRST;
            default:                          st_d = ST_PAIR_FIRST;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_PAIR_FIRST;
        else        st_q <= st_d;
    end

    // output and holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_i     <= '0;
            a_q     <= '0;
            b_i     <= '0;
            b_q     <= '0;
            ovr_i   <= 1'b0;
            ovr_q   <= 1'b0;
            drdy    <= 1'b0;
            hold_i  <= '0;
            hold_q  <= '0;
            hold_oi <= 1'b0;
            hold_oq <= 1'b0;
        end else begin
            drdy <= 1'b0;
            unique case (st_eff)
                ST_PAIR_FIRST: begin
                    if (fwd && !dmux2) begin
                        a_i   <= ci;
                        a_q   <= cq;
                        b_i   <= '0;
                        b_q   <= '0;
                        ovr_i <= oi;
                        ovr_q <= oq;
                        drdy  <= 1'b1;
                    end else if (fwd) begin
                        hold_i  <= ci;
                        hold_q  <= cq;
                        hold_oi <= oi;
                        hold_oq <= oq;
                    end
                end
                ST_PAIR_SECOND: begin
                    if (fwd) begin
                        a_i   <= hold_i;
                        a_q   <= hold_q;
                        b_i   <= ci;
                        b_q   <= cq;
                        ovr_i <= hold_oi | oi;
                        ovr_q <= hold_oq | oq;
                        drdy  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cvt_out_fmt.sv
module cvt_out_fmt
    import cvt_out_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned RATIO = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] i_data,
    input  logic          i_ovr,
    input  logic [DW-1:0] q_data,
    input  logic          q_ovr,
    input  logic          cfg_gray,
    input  logic          cfg_dmux2,
    input  logic          cfg_decim,
    output logic [DW-1:0] a_i,
    output logic [DW-1:0] a_q,
    output logic [DW-1:0] b_i,
    output logic [DW-1:0] b_q,
    output logic          ovr_i,
    output logic          ovr_q,
    output logic          drdy
);
    logic [NUM_CH-1:0][DW-1:0] raw, coded;
    logic [NUM_CH-1:0]         flag;
    mode_t                     mode;
    logic                      fwd, restart;

    assign raw[0]  = i_data;
    assign raw[1]  = q_data;
    assign flag[0] = i_ovr;
    assign flag[1] = q_ovr;
    assign mode.dmux2 = cfg_dmux2;
    assign mode.decim = cfg_decim;

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            cvt_coder #(.DW(DW)) coder_i (
                .raw     (raw[ch]),
                .ovr     (flag[ch]),
                .gray_en (cfg_gray),
                .coded   (coded[ch])
            );
        end
    endgenerate

    cvt_decim #(.RATIO(RATIO)) decim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .mode    (mode),
        .fwd     (fwd),
        .restart (restart)
    );

    cvt_demux_fsm #(.DW(DW)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fwd     (fwd),
        .restart (restart),
        .dmux2   (cfg_dmux2),
        .ci      (coded[0]),
        .cq      (coded[1]),
        .oi      (flag[0]),
        .oq      (flag[1]),
        .a_i     (a_i),
        .a_q     (a_q),
        .b_i     (b_i),
        .b_q     (b_q),
        .ovr_i   (ovr_i),
        .ovr_q   (ovr_q),
        .drdy    (drdy)
    );
endmodule

// File: rtl/cvt_out_fmt_chk.sv
module cvt_out_fmt_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic [DW-1:0] i_data,
    input logic          i_ovr,
    input logic          cfg_gray,
    input logic          cfg_dmux2,
    input logic [DW-1:0] a_i,
    input logic [DW-1:0] b_i,
    input logic [DW-1:0] b_q,
    input logic          drdy
);
    // R8
    drdy_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |-> $past(smp_vld));

    // R8
    hold_between_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy |-> $stable(a_i) && $stable(b_i));

    // R7
    single_port_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy && !$past(cfg_dmux2) |-> (b_i == '0) && (b_q == '0));

    // R2
    binary_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy && !$past(cfg_dmux2) && !$past(cfg_gray) |-> a_i == $past(i_data));

    // R4
    gray_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy && !$past(cfg_dmux2) && $past(cfg_gray) && $past(i_ovr)
        |-> (a_i[DW-2:0] == '0) && (a_i[DW-1] == $past(i_data[DW-1])));
endmodule

bind cvt_out_fmt cvt_out_fmt_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .i_data    (i_data),
    .i_ovr     (i_ovr),
    .cfg_gray  (cfg_gray),
    .cfg_dmux2 (cfg_dmux2),
    .a_i       (a_i),
    .b_i       (b_i),
    .b_q       (b_q),
    .drdy      (drdy)
);

// File: tb/cvt_out_fmt_tb_top.sv
module cvt_out_fmt_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] i_data = '0, q_data = '0;
    logic          i_ovr = 1'b0, q_ovr = 1'b0;
    logic          cfg_gray = 1'b0, cfg_dmux2 = 1'b0, cfg_decim = 1'b0;
    logic [DW-1:0] a_i, a_q, b_i, b_q;
    logic          ovr_i, ovr_q, drdy;

    int    n_run = 0, n_fail = 0, cyc = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    cvt_out_fmt dut_i (.*);

    // behavioural reference
    logic [DW-1:0] e_ai = '0, e_aq = '0, e_bi = '0, e_bq = '0;
    logic          e_oi = 1'b0, e_oq = 1'b0, e_dr = 1'b0;
    int            seen = 0;
    logic [DW-1:0] pend_i[$], pend_q[$];
    logic          pend_oi[$], pend_oq[$];
    logic [1:0]    last_mode = 2'b00;

    function automatic logic [DW-1:0] code(input logic [DW-1:0] v, input logic o, input logic g);
        logic [DW-1:0] r;
        if (!g) return v;
        if (o) begin
            r = '0;
            r[DW-1] = v[DW-1];
            return r;
        end
        for (int k = 0; k < DW; k++) r[k] = (k == DW - 1) ? v[k] : (v[k] ^ v[k+1]);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {e_ai, e_aq, e_bi, e_bq} = '0;
            {e_oi, e_oq, e_dr} = '0;
            seen = 0;
            pend_i.delete(); pend_q.delete(); pend_oi.delete(); pend_oq.delete();
            last_mode = 2'b00;
        end else begin
            e_dr = 1'b0;
            if ({cfg_dmux2, cfg_decim} != last_mode) begin
                seen = 0;
                pend_i.delete(); pend_q.delete(); pend_oi.delete(); pend_oq.delete();
            end
            if (smp_vld) begin
                if (!cfg_decim || (seen % 16) == 0) begin
                    if (!cfg_dmux2) begin
                        e_ai = code(i_data, i_ovr, cfg_gray);
                        e_aq = code(q_data, q_ovr, cfg_gray);
                        e_bi = '0; e_bq = '0;
                        e_oi = i_ovr; e_oq = q_ovr; e_dr = 1'b1;
                    end else if (pend_i.size() == 0) begin
                        pend_i.push_back(code(i_data, i_ovr, cfg_gray));
                        pend_q.push_back(code(q_data, q_ovr, cfg_gray));
                        pend_oi.push_back(i_ovr);
                        pend_oq.push_back(q_ovr);
                    end else begin
                        e_ai = pend_i.pop_front();
                        e_aq = pend_q.pop_front();
                        e_bi = code(i_data, i_ovr, cfg_gray);
                        e_bq = code(q_data, q_ovr, cfg_gray);
                        e_oi = pend_oi.pop_front() | i_ovr;
                        e_oq = pend_oq.pop_front() | q_ovr;
                        e_dr = 1'b1;
                    end
                end
                seen++;
            end
            last_mode = {cfg_dmux2, cfg_decim};
        end
    end

    // comparison, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            n_run++;
            if ({a_i, a_q, b_i, b_q, ovr_i, ovr_q, drdy} !== {e_ai, e_aq, e_bi, e_bq, e_oi, e_oq, e_dr}) begin
                n_fail++;
                $display("FAIL %s: got a=%h/%h b=%h/%h ovr=%b%b drdy=%b exp a=%h/%h b=%h/%h ovr=%b%b drdy=%b",
                         tag, a_i, a_q, b_i, b_q, ovr_i, ovr_q, drdy,
                         e_ai, e_aq, e_bi, e_bq, e_oi, e_oq, e_dr);
            end
        end
    end

    task automatic smp(input logic [DW-1:0] di, input logic oi, input logic [DW-1:0] dq, input logic oq);
        @(negedge clk);
        smp_vld = 1'b1; i_data = di; i_ovr = oi; q_data = dq; q_ovr = oq;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic burst(input int n, input int ovr_pct, input bit gaps);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_vld = gaps ? 1'($urandom_range(0, 1)) : 1'b1;
            i_data = DW'($urandom); q_data = DW'($urandom);
            i_ovr = ($urandom_range(0, 99) < ovr_pct);
            q_ovr = ($urandom_range(0, 99) < ovr_pct);
        end
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic g, input logic d2, input logic dc);
        @(negedge clk);
        cfg_gray = g; cfg_dmux2 = d2; cfg_decim = dc;
    endtask

    initial begin
        tag = "R1";   idle(4);
        @(negedge clk); rst_n = 1'b1;
        tag = "R2";   smp(8'h5A, 1'b1, 8'hC3, 1'b0); burst(40, 30, 1'b0); burst(40, 30, 1'b1);
        tag = "R3";   set_mode(1, 0, 0); smp(8'hB6, 1'b0, 8'h01, 1'b0); burst(60, 0, 1'b1);
        tag = "R4";   smp(8'hF3, 1'b1, 8'h7F, 1'b1); burst(60, 60, 1'b0);
        tag = "R7";   burst(30, 20, 1'b1);
        tag = "R5";   set_mode(0, 1, 0); idle(2); smp(8'h11, 1'b0, 8'h22, 1'b0); idle(3);
                      smp(8'h33, 1'b0, 8'h44, 1'b0); burst(60, 0, 1'b1);
        tag = "R6";   smp(8'h01, 1'b1, 8'h02, 1'b0); smp(8'h03, 1'b0, 8'h04, 1'b1);
                      set_mode(1, 1, 0); burst(80, 40, 1'b1);
        tag = "R8";   idle(5); burst(50, 10, 1'b1);
        tag = "R9";   set_mode(0, 0, 1); idle(2); burst(100, 10, 1'b0); burst(120, 10, 1'b1);
                      set_mode(1, 1, 1); burst(200, 10, 1'b0);
        tag = "R10";  set_mode(0, 1, 0); idle(2); smp(8'hAA, 1'b1, 8'h55, 1'b1);
                      set_mode(0, 0, 0); smp(8'h0F, 1'b0, 8'hF0, 1'b0);
                      set_mode(0, 1, 0); smp(8'h12, 1'b0, 8'h34, 1'b0); set_mode(1, 1, 0);
                      smp(8'h56, 1'b0, 8'h78, 1'b0);
                      set_mode(0, 0, 1); burst(7, 0, 1'b0); set_mode(0, 0, 0); set_mode(0, 0, 1);
                      burst(40, 0, 1'b0);
        // mode change in the same cycle as a sample
        @(negedge clk); cfg_decim = 1'b0; cfg_dmux2 = 1'b1; smp_vld = 1'b1; i_data = 8'h9C; q_data = 8'h3E;
        @(negedge clk); smp_vld = 1'b1; i_data = 8'h21; q_data = 8'h43;
        @(negedge clk); smp_vld = 1'b0;
        idle(4);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule